// File: doc/BRIEF.md
# Stepping Motor Excitation Pattern Generator

This block drives the phase windings of a stepping motor. It holds an excitation pattern in a shift register and shows it on a 4-bit output latch. Each pulse from an external timer match moves the pattern forward by exactly one step. Software chooses one of four modes:

- a free pattern mode, where the bits are written directly;
- a single-phase full-step mode;
- a two-phase full-step mode;
- a half-step mode, which alternates between one and two active phases.

A direction bit makes the motor turn forward or backward.

Software sets up the block through two write strobes. The configuration strobe sets the mode, the direction and the write style. The pattern strobe loads a pattern. The write style decides what a pattern write changes:

- With the whole-load style, the shift register and the visible latch are both loaded at once.
- With the staged style, only the low half of the shift register is loaded. The latch keeps its value until the next step.

Top module: `stepper_pattern_gen`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the output latch, the mode, the direction and the write style. `phaseOut` then reads 0000.
- R2: With write style 0, a pattern write loads all 8 bits of `patData` into the shift register. It also loads the latch with the view of that value under the current mode. The view is bits [3:0] in modes 00, 01 and 10. In mode 11, `phaseOut[k]` takes register bit 2k.
- R3: With write style 1, a pattern write loads only shift register bits [3:0] from `patData[3:0]`. `phaseOut` is left unchanged.
- R4: In mode 00 (free), a step copies shift register bits [3:0] to the latch. The shift register itself is not changed.
- R5: In mode 01 (single-phase), a step with direction 0 rotates shift register bits [3:0] one place toward the higher bit, with bit 3 wrapping to bit 0. The result is copied to `phaseOut`, so a 1000-style single one stays a single active phase.
- R6: Mode 10 (two-phase) rotates bits [3:0] the same way as R5. A 1100 start therefore keeps two adjacent phases active on every step.
- R7: In mode 11 (half-step), a step rotates all 8 register bits by one place, and `phaseOut[k]` shows register bit 2k. Three consecutive ones give alternating one-phase and two-phase outputs over an 8-step cycle.
- R8: Direction 1 rotates toward the lower bit instead, with bit 0 wrapping to the top bit. This applies to the 4-bit rotation and to the 8-bit rotation.
- R9: A `stepTrig` pulse in the same cycle as a pattern write or a configuration write is ignored, and the write takes effect.
- R10: With no trigger and no pattern write, `phaseOut` and the shift register hold their values. Each cycle with `stepTrig` high advances exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode: 00 free, 01 single-phase, 10 two-phase, 11 half-step |
| cfgDir | input | 1 | Direction: 0 forward (toward higher bit), 1 reverse |
| cfgWrMode | input | 1 | Write style: 0 whole load, 1 staged low-half load |
| patWe | input | 1 | Pattern write strobe |
| patData | input | 8 | Pattern write data |
| stepTrig | input | 1 | Step pulse from a timer match |
| phaseOut | output | 4 | Excitation output latch |

## Verification
The bench builds the block with its default of 4 phases, so the shift register is 8 bits wide. At that width every 4-bit start pattern can be stepped through both full-step modes in both directions. All 256 register values can also be walked through a complete 8-step half-step cycle in each direction, with the expected outputs computed by bit rotation in the bench. Directed sequences then cover the staged write style, the free mode and triggers that coincide with writes.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_HALF   = 2'd3
  } stepMode_e;

  typedef struct packed {
    logic      loadFull;
    logic      loadLow;
    logic      advance;
    logic      reverse;
    stepMode_e mode;
  } stepStrobe_t;
endpackage

// File: rtl/stepgen_ctrl.sv
module stepgen_ctrl
  import stepgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWe,
  input  logic [1:0]  cfgMode,
  input  logic        cfgDir,
  input  logic        cfgWrMode,
  input  logic        patWe,
  input  logic        stepTrig,
  output stepStrobe_t strb,
  output logic        wrModeQ
);
  stepMode_e modeQ;
  logic      dirQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= MODE_FREE;
      dirQ    <= 1'b0;
      wrModeQ <= 1'b0;
    end else if (cfgWe) begin
      modeQ   <= stepMode_e'(cfgMode);
      dirQ    <= cfgDir;
      wrModeQ <= cfgWrMode;
    end
  end

  always_comb begin
    strb.loadFull = patWe & ~wrModeQ;
    strb.loadLow  = patWe & wrModeQ;
    // any write in the same cycle wins over the step pulse
    strb.advance  = stepTrig & ~patWe & ~cfgWe;
    strb.reverse  = dirQ;
    strb.mode     = modeQ;
  end
endmodule

// File: rtl/stepgen_dp.sv
module stepgen_dp
  import stepgen_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  stepStrobe_t       strb,
  input  logic [2*PHASES-1:0] patData,
  output logic [2*PHASES-1:0] srQ,
  output logic [PHASES-1:0] latchQ
);
  localparam int REGW = 2 * PHASES;

  logic [REGW-1:0]   nextSr;
  logic [REGW-1:0]   rotFull;
  logic [PHASES-1:0] rotLow;
  logic [PHASES-1:0] evenView;
  logic [PHASES-1:0] nextView;
  logic [PHASES-1:0] nextLatch;

  always_comb begin
    if (strb.reverse) begin
      rotLow  = {srQ[0], srQ[PHASES-1:1]};
      rotFull = {srQ[0], srQ[REGW-1:1]};
    end else begin
      rotLow  = {srQ[PHASES-2:0], srQ[PHASES-1]};
      rotFull = {srQ[REGW-2:0], srQ[REGW-1]};
    end
  end

  always_comb begin
    nextSr = srQ;
    if (strb.loadFull) begin
      nextSr = patData;
    end else if (strb.loadLow) begin
      nextSr = {srQ[REGW-1:PHASES], patData[PHASES-1:0]};
    end else if (strb.advance) begin
      unique case (strb.mode)
        MODE_FREE:              nextSr = srQ;
        MODE_SINGLE, MODE_DUAL: nextSr = {srQ[REGW-1:PHASES], rotLow};
        MODE_HALF:              nextSr = rotFull;
        default:                nextSr = srQ;
      endcase
    end
  end

  // half-step view: every second register bit drives one phase
  for (genvar k = 0; k < PHASES; k++) begin : g_even
    assign evenView[k] = nextSr[2*k];
  end

  assign nextView = (strb.mode == MODE_HALF) ? evenView : nextSr[PHASES-1:0];

  always_comb begin
    nextLatch = latchQ;
    if (strb.loadFull) begin
      nextLatch = nextView;
    end else if (strb.advance) begin
      nextLatch = (strb.mode == MODE_FREE) ? srQ[PHASES-1:0] : nextView;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srQ    <= '0;
      latchQ <= '0;
    end else begin
      srQ    <= nextSr;
      latchQ <= nextLatch;
    end
  end
endmodule

// File: rtl/stepper_pattern_gen.sv
module stepper_pattern_gen
  import stepgen_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWe,
  input  logic [1:0]          cfgMode,
  input  logic                cfgDir,
  input  logic                cfgWrMode,
  input  logic                patWe,
  input  logic [2*PHASES-1:0] patData,
  input  logic                stepTrig,
  output logic [PHASES-1:0]   phaseOut
);
  localparam int REGW = 2 * PHASES;

  stepStrobe_t     strb;
  logic            curWrMode;
  logic [1:0]      curMode;
  logic            curDir;
  logic [REGW-1:0] shiftReg;

  stepgen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgMode  (cfgMode),
    .cfgDir   (cfgDir),
    .cfgWrMode(cfgWrMode),
    .patWe    (patWe),
    .stepTrig (stepTrig),
    .strb     (strb),
    .wrModeQ  (curWrMode)
  );

  stepgen_dp #(.PHASES(PHASES)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .patData(patData),
    .srQ    (shiftReg),
    .latchQ (phaseOut)
  );

  assign curMode = strb.mode;
  assign curDir  = strb.reverse;
endmodule

// File: rtl/stepper_pattern_gen_chk.sv
module stepper_pattern_gen_chk #(
  parameter int PHASES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfgWe,
  input logic                patWe,
  input logic [2*PHASES-1:0] patData,
  input logic                stepTrig,
  input logic [PHASES-1:0]   phaseOut,
  input logic [2*PHASES-1:0] shiftReg,
  input logic [1:0]          curMode,
  input logic                curDir,
  input logic                curWrMode
);
  localparam int REGW = 2 * PHASES;
  logic stepOk;
  assign stepOk = stepTrig && !patWe && !cfgWe;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phaseOut == '0 && shiftReg == '0));

  p_staged_write_r3: assert property (@(posedge clk) disable iff (rst)
    (patWe && curWrMode) |=> $stable(phaseOut));

  p_free_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (stepOk && curMode == 2'd0) |=>
      (phaseOut == $past(shiftReg[PHASES-1:0]) && $stable(shiftReg)));

  p_rotate_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (stepOk && (curMode == 2'd1 || curMode == 2'd2) && !curDir) |=>
      (shiftReg[PHASES-1:0] == {$past(shiftReg[PHASES-2:0]), $past(shiftReg[PHASES-1])}
       && phaseOut == shiftReg[PHASES-1:0]));

  p_rotate_rev_r8: assert property (@(posedge clk) disable iff (rst)
    (stepOk && (curMode == 2'd1 || curMode == 2'd2) && curDir) |=>
      (shiftReg[PHASES-1:0] == {$past(shiftReg[0]), $past(shiftReg[PHASES-1:1])}));

  p_half_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (stepOk && curMode == 2'd3) |=>
      ($countones(shiftReg) == $countones($past(shiftReg))));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (stepTrig && patWe && !curWrMode) |=> (shiftReg == $past(patData)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!stepTrig && !patWe) |=> ($stable(phaseOut) && $stable(shiftReg)));
endmodule

bind stepper_pattern_gen stepper_pattern_gen_chk #(.PHASES(PHASES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgWe    (cfgWe),
  .patWe    (patWe),
  .patData  (patData),
  .stepTrig (stepTrig),
  .phaseOut (phaseOut),
  .shiftReg (shiftReg),
  .curMode  (curMode),
  .curDir   (curDir),
  .curWrMode(curWrMode)
);

// File: tb/stepper_pattern_gen_tb.sv
`timescale 1ns/1ps
module stepper_pattern_gen_tb;
  localparam int PH = 4;
  localparam int RW = 2 * PH;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgMode = '0;
  logic          cfgDir = 1'b0;
  logic          cfgWrMode = 1'b0;
  logic          patWe = 1'b0;
  logic [RW-1:0] patData = '0;
  logic          stepTrig = 1'b0;
  logic [PH-1:0] phaseOut;

  int compared = 0;
  int mismatched = 0;
  logic [RW-1:0] expSr;
  logic [PH-1:0] expOut;

  always #2.5 clk = ~clk;

  stepper_pattern_gen #(.PHASES(PH)) u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgDir(cfgDir),
    .cfgWrMode(cfgWrMode), .patWe(patWe), .patData(patData),
    .stepTrig(stepTrig), .phaseOut(phaseOut)
  );

  function automatic logic [PH-1:0] evenBits(input logic [RW-1:0] v);
    logic [PH-1:0] r;
    for (int k = 0; k < PH; k++) r[k] = v[2*k];
    return r;
  endfunction

  function automatic logic [PH-1:0] rot4(input logic [PH-1:0] v, input logic rev);
    return rev ? {v[0], v[PH-1:1]} : {v[PH-2:0], v[PH-1]};
  endfunction

  function automatic logic [RW-1:0] rot8(input logic [RW-1:0] v, input logic rev);
    return rev ? {v[0], v[RW-1:1]} : {v[RW-2:0], v[RW-1]};
  endfunction

  task automatic check(input logic [PH-1:0] exp, input string req);
    compared++;
    if (phaseOut !== exp) begin
      mismatched++;
      $display("FAIL %s: phaseOut=%b expected=%b", req, phaseOut, exp);
    end
  endtask

  task automatic finishEdge;
    @(posedge clk);
    #1;
    cfgWe = 1'b0; patWe = 1'b0; stepTrig = 1'b0;
  endtask

  task automatic doCfg(input logic [1:0] m, input logic d, input logic wm);
    @(negedge clk);
    cfgWe = 1'b1; cfgMode = m; cfgDir = d; cfgWrMode = wm;
    finishEdge();
  endtask

  task automatic doPat(input logic [RW-1:0] v);
    @(negedge clk);
    patWe = 1'b1; patData = v;
    finishEdge();
  endtask

  task automatic doStep(input logic withPat, input logic withCfg, input logic [RW-1:0] v);
    @(negedge clk);
    stepTrig = 1'b1; patWe = withPat; patData = v; cfgWe = withCfg;
    finishEdge();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check('0, "R1 reset output");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check('0, "R1 after reset release");

    // R5, R6, R8: every 4-bit start, both full-step modes, both directions
    for (int m = 1; m <= 2; m++) begin
      for (int d = 0; d < 2; d++) begin
        doCfg(2'(m), 1'(d), 1'b0);
        for (int p = 0; p < 16; p++) begin
          doPat(RW'(p));
          expSr = RW'(p);
          check(expSr[PH-1:0], "R2 whole load low view");
          for (int s = 0; s < 5; s++) begin
            doStep(1'b0, 1'b0, '0);
            expSr[PH-1:0] = rot4(expSr[PH-1:0], 1'(d));
            check(expSr[PH-1:0], d ? "R8 reverse 4-bit" : (m == 1 ? "R5 single-phase" : "R6 two-phase"));
          end
        end
      end
    end

    // R7, R8: every 8-bit value through a full half-step cycle
    for (int d = 0; d < 2; d++) begin
      doCfg(2'd3, 1'(d), 1'b0);
      for (int p = 0; p < 256; p++) begin
        doPat(RW'(p));
        expSr = RW'(p);
        check(evenBits(expSr), "R2 whole load half view");
        for (int s = 0; s < 9; s++) begin
          doStep(1'b0, 1'b0, '0);
          expSr = rot8(expSr, 1'(d));
          check(evenBits(expSr), d ? "R8 reverse half-step" : "R7 half-step");
        end
      end
    end

    // R3: staged write leaves the latch alone; the next step uses the new low half
    doCfg(2'd1, 1'b0, 1'b0);
    doPat(8'h01);
    check(4'b0001, "R2 load 0001");
    doCfg(2'd1, 1'b0, 1'b1);
    doPat(8'hF4);
    check(4'b0001, "R3 staged write keeps latch");
    doStep(1'b0, 1'b0, '0);
    check(4'b1000, "R3 step from staged 0100");

    // R4: free mode copies the staged nibble without rotating it
    doCfg(2'd0, 1'b0, 1'b1);
    doPat(8'h03);
    check(4'b1000, "R3 staged write in free mode");
    doStep(1'b0, 1'b0, '0);
    check(4'b0011, "R4 free copy");
    doStep(1'b0, 1'b0, '0);
    check(4'b0011, "R4 free copy no shift");
    doPat(8'h05);
    doStep(1'b0, 1'b0, '0);
    check(4'b0101, "R4 free copy new pattern");

    // R9: a trigger coinciding with a write is ignored
    doCfg(2'd1, 1'b0, 1'b0);
    doPat(8'h01);
    doStep(1'b1, 1'b0, 8'h02);
    check(4'b0010, "R9 pattern write beats trigger");
    doStep(1'b0, 1'b1, '0);
    check(4'b0010, "R9 config write beats trigger");
    doStep(1'b0, 1'b0, '0);
    check(4'b0100, "R9 following step");

    // R10: idle cycles hold, back-to-back triggers advance once each
    repeat (4) @(posedge clk);
    #1;
    check(4'b0100, "R10 hold while idle");
    @(negedge clk);
    stepTrig = 1'b1;
    @(posedge clk); #1;
    check(4'b1000, "R10 first of back-to-back");
    @(posedge clk); #1;
    check(4'b0001, "R10 second of back-to-back");
    stepTrig = 1'b0;

    // R1: reset mid-run clears output and configuration
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check('0, "R1 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    doStep(1'b0, 1'b0, '0);
    check('0, "R1 cleared register after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule